// File: doc/BRIEF.md
# Vector Interface Command Parser

The parser takes a stream of 32-bit words from a DMA channel and turns it into actions for the front end of a vector coprocessor. A word that arrives while the parser is idle is a command word. It holds an interrupt flag in bit 31, an opcode in bits [30:24], a count in bits [23:16] and an immediate in bits [15:0]. Commands without a payload act at once: they update a register or report an error. Commands with a payload put the parser into a data-wait state. In that state every word that follows goes to one sink until the payload is used up: the microcode memory write port, the graphics passthrough port, or the unpack engine port.

A DMA transfer may end in the middle of a payload. The parser keeps the remaining word count, so the next burst carries on with that command and is not decoded again. When a burst starts with its DMA tag, the two 32-bit words of the tag (the first 8 bytes of the first quadword) are accepted and dropped before any parsing. The input uses a valid/ready handshake. Ready goes low while the active sink is stalled, so no word is lost.

Top module: `vifp_parser`

## Requirements
- R1: Opcode 0x00 has no payload and produces no output. The word after it is decoded as a new command.
- R2: Opcode 0x01 loads the cycle register. On the cycle after the command word is accepted, `cyc_we` is high for one cycle, `cyc_wl` shows immediate bits [15:8] and `cyc_cl` shows immediate bits [7:0]. Both values hold until the next such command.
- R3: Opcode 0x4A uploads 2×count payload words, with a count of 0 meaning 256. Payload word k is written with `code_we` high at word address (2×immediate + k) modulo 2^CODE_AW, in the cycle that word is accepted.
- R4: Opcodes 0x50 and 0x51 pass 4×immediate payload words, unchanged and in order, to `gfx_data` with `gfx_valid` high. An immediate of 0 means 65536 quadwords.
- R5: An opcode of 0x60 or above is an unpack command. `unp_cmd` holds its command word while its payload is on `unp_data`. The payload length is ceil(n×b/32) words, where n is the count (0 means 256) and b is the number of bits per vector: opcode bits [3:2]+1 components of 32, 16 or 8 bits for opcode bits [1:0] = 0, 1, 2, and a fixed 16 bits when bits [1:0] = 3.
- R6: `data_wait` is high from the cycle after a payload command is accepted until the cycle after its last payload word is accepted. While it is high, every accepted word that is not a tag word is payload, including words in later bursts. At most one sink strobe is high in any cycle.
- R7: A word presented with `in_sop` and `in_tagged` both high, and the word after it, are accepted with `in_ready` high. Neither reaches a sink, and neither is decoded as a command.
- R8: While idle, or during a code upload, `in_ready` is high. During a graphics or unpack payload, `in_ready` follows that sink's ready, and no word is dropped or repeated.
- R9: A command word with an opcode not named in R1–R5 is treated as having no payload. `cmd_err` pulses for one cycle on the cycle after such a word, or after any command word with bit 31 set.
- R10: After reset the parser is idle: `data_wait`, `cyc_we` and `cmd_err` are low, the cycle register is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Word is the first of a DMA burst |
| in_tagged | input | 1 | The burst starts with a two-word DMA tag |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted |
| cyc_we | output | 1 | Cycle register update strobe |
| cyc_wl | output | 8 | Write length field of the cycle register |
| cyc_cl | output | 8 | Cycle length field of the cycle register |
| code_we | output | 1 | Microcode memory write enable |
| code_addr | output | CODE_AW | Microcode memory word address |
| code_data | output | 32 | Microcode memory write data |
| gfx_valid | output | 1 | Graphics passthrough word valid |
| gfx_data | output | 32 | Graphics passthrough word |
| gfx_ready | input | 1 | Graphics sink ready |
| unp_valid | output | 1 | Unpack payload word valid |
| unp_data | output | 32 | Unpack payload word |
| unp_cmd | output | 32 | Command word of the active unpack |
| unp_ready | input | 1 | Unpack engine ready |
| data_wait | output | 1 | A payload is still owed to the current command |
| cmd_err | output | 1 | Unknown opcode or interrupt flag seen |

## Verification
The assertions assume that a tag-marked start of burst is never presented on the word that directly follows another tag-marked start. They also assume that sink ready signals change only between clock edges. The stimulus follows both rules: each tagged burst starts with `in_sop` and `in_tagged` on its first word only, and both ready signals are driven from a fixed stall pattern that updates on the falling edge. Bursts are split partway through code, graphics and unpack payloads, with idle gaps between them, so that resumption is exercised while the stalls are in effect.

// File: rtl/vifp_pkg.sv
// Package: shared types, opcode values and the payload-length rule for unpacks.
// Assumes command words are laid out as {irq, opcode[6:0], count[7:0], imm[15:0]}.
package vifp_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned REM_W  = 19;   // enough for 65536 quadwords of 4 words
    localparam logic [REM_W-1:0] GFX_MAX_WORDS = REM_W'(19'h40000);

    localparam logic [6:0] OP_NOP     = 7'h00;
    localparam logic [6:0] OP_CYCLE   = 7'h01;
    localparam logic [6:0] OP_CODE    = 7'h4A;
    localparam logic [6:0] OP_GFX_A   = 7'h50;
    localparam logic [6:0] OP_GFX_B   = 7'h51;
    localparam logic [6:0] OP_UNP_MIN = 7'h60;

    typedef enum logic [2:0] {
        K_NOP,
        K_CYCLE,
        K_CODE,
        K_GFX,
        K_UNP,
        K_BAD
    } cmd_kind_e;

    typedef struct packed {
        logic        irq;
        logic [6:0]  op;
        logic [7:0]  cnt;
        logic [15:0] imm;
    } cmd_word_t;

    // Number of 32-bit payload words an unpack command consumes.
    function automatic logic [REM_W-1:0] unpack_words(input logic [6:0] op,
                                                      input logic [7:0] cnt);
        logic [8:0]  n;
        logic [2:0]  comps;
        logic [7:0]  bpv;
        logic [16:0] bits;
        n     = (cnt == 8'd0) ? 9'd256 : {1'b0, cnt};
        comps = {1'b0, op[3:2]} + 3'd1;
        case (op[1:0])
            2'd0:    bpv = {comps, 5'b0};
            2'd1:    bpv = {1'b0, comps, 4'b0};
            2'd2:    bpv = {2'b0, comps, 3'b0};
            default: bpv = 8'd16;
        endcase
        bits = 17'(n) * 17'(bpv);
        return REM_W'((bits + 17'd31) >> 5);
    endfunction

endpackage

// File: rtl/vifp_tag_strip.sv
// Tag stripper: drops the two tag words at the head of a tagged DMA burst.
// Assumes in_sop/in_tagged are meaningful on the first word of a burst only.
module vifp_tag_strip
    import vifp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_tagged,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              s_valid,
    output logic [WORD_W-1:0] s_data,
    input  logic              s_ready
);

    logic skip_q;   // second tag word still to be dropped
    logic drop;

    // Decide whether the presented word belongs to a tag.
    always_comb begin
        drop     = skip_q | (in_sop & in_tagged);
        s_valid  = in_valid & ~drop;
        s_data   = in_data;
        in_ready = drop | s_ready;
    end

    // Track the second word of the tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else if (in_valid && drop) begin
            skip_q <= ~skip_q;
        end
    end

endmodule

// File: rtl/vifp_cmd_decode.sv
// Command decoder: classifies a command word and works out its payload length.
// Pure combinational; the result is only used on the cycle a command is taken.
module vifp_cmd_decode
    import vifp_pkg::*;
(
    input  cmd_word_t        cmd,
    output cmd_kind_e        kind,
    output logic [REM_W-1:0] pay_len
);

    logic [8:0] n9;

    // Map the opcode to a command class.
    always_comb begin
        if (cmd.op == OP_NOP)                              kind = K_NOP;
        else if (cmd.op == OP_CYCLE)                       kind = K_CYCLE;
        else if (cmd.op == OP_CODE)                        kind = K_CODE;
        else if (cmd.op == OP_GFX_A || cmd.op == OP_GFX_B) kind = K_GFX;
        else if (cmd.op >= OP_UNP_MIN)                     kind = K_UNP;
        else                                               kind = K_BAD;
    end

    // Payload length in 32-bit words for each class.
    always_comb begin
        n9 = (cmd.cnt == 8'd0) ? 9'd256 : {1'b0, cmd.cnt};
        case (kind)
            K_CODE:  pay_len = REM_W'({n9, 1'b0});
            K_GFX:   pay_len = (cmd.imm == 16'd0) ? GFX_MAX_WORDS
                                                  : REM_W'({cmd.imm, 2'b00});
            K_UNP:   pay_len = unpack_words(cmd.op, cmd.cnt);
            default: pay_len = '0;
        endcase
    end

endmodule

// File: rtl/vifp_payload_seq.sv
// Payload sequencer: takes command words while idle, then steers payload words
// to one sink until the remaining count reaches zero. The count survives idle
// gaps, so a payload may span several DMA bursts.
module vifp_payload_seq
    import vifp_pkg::*;
#(
    parameter int unsigned CODE_AW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    input  logic [WORD_W-1:0]  s_data,
    output logic               s_ready,
    input  cmd_kind_e          dec_kind,
    input  logic [REM_W-1:0]   dec_len,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [WORD_W-1:0]  code_data,
    output logic               gfx_valid,
    output logic [WORD_W-1:0]  gfx_data,
    input  logic               gfx_ready,
    output logic               unp_valid,
    output logic [WORD_W-1:0]  unp_data,
    output logic [WORD_W-1:0]  unp_cmd,
    input  logic               unp_ready,
    output logic               data_wait,
    output logic               cyc_we,
    output logic [7:0]         cyc_wl,
    output logic [7:0]         cyc_cl,
    output logic               cmd_err
);

    cmd_word_t          w;
    cmd_kind_e          sink_q;
    logic               wait_q;
    logic [REM_W-1:0]   remain_q;
    logic [CODE_AW-1:0] addr_q;
    logic [WORD_W-1:0]  cmd_q;
    logic               sink_rdy;
    logic               take_cmd;
    logic               take_dat;

    // Sink readiness and handshake qualification.
    always_comb begin
        w = s_data;
        case (sink_q)
            K_GFX:   sink_rdy = gfx_ready;
            K_UNP:   sink_rdy = unp_ready;
            default: sink_rdy = 1'b1;
        endcase
        s_ready  = ~wait_q | sink_rdy;
        take_cmd = s_valid & s_ready & ~wait_q;
        take_dat = s_valid & s_ready &  wait_q;
    end

    // Steer payload words to the active sink.
    always_comb begin
        code_we   = s_valid & wait_q & (sink_q == K_CODE);
        gfx_valid = s_valid & wait_q & (sink_q == K_GFX);
        unp_valid = s_valid & wait_q & (sink_q == K_UNP);
        code_addr = addr_q;
        code_data = s_data;
        gfx_data  = s_data;
        unp_data  = s_data;
        unp_cmd   = cmd_q;
        data_wait = wait_q;
    end

    // Command capture and remaining-count tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q   <= 1'b0;
            sink_q   <= K_NOP;
            remain_q <= '0;
            addr_q   <= '0;
            cmd_q    <= '0;
        end else if (take_cmd) begin
            cmd_q <= s_data;
            if (dec_kind == K_CODE || dec_kind == K_GFX || dec_kind == K_UNP) begin
                wait_q   <= 1'b1;
                sink_q   <= dec_kind;
                remain_q <= dec_len;
                addr_q   <= CODE_AW'({w.imm, 1'b0});
            end
        end else if (take_dat) begin
            remain_q <= remain_q - 1'b1;
            addr_q   <= addr_q + 1'b1;
            if (remain_q == REM_W'(1)) begin
                wait_q <= 1'b0;
            end
        end
    end

    // Register-update and error strobes, one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_we  <= 1'b0;
            cyc_wl  <= '0;
            cyc_cl  <= '0;
            cmd_err <= 1'b0;
        end else begin
            cyc_we  <= take_cmd & (dec_kind == K_CYCLE);
            cmd_err <= take_cmd & ((dec_kind == K_BAD) | w.irq);
            if (take_cmd && dec_kind == K_CYCLE) begin
                cyc_wl <= w.imm[15:8];
                cyc_cl <= w.imm[7:0];
            end
        end
    end

endmodule

// File: rtl/vifp_parser.sv
// Top: DMA word stream -> tag stripper -> decoder + payload sequencer.
// Assumes the microcode memory accepts a write on every cycle.
module vifp_parser
    import vifp_pkg::*;
#(
    parameter int unsigned CODE_AW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_tagged,
    input  logic [31:0]        in_data,
    output logic               in_ready,
    output logic               cyc_we,
    output logic [7:0]         cyc_wl,
    output logic [7:0]         cyc_cl,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [31:0]        code_data,
    output logic               gfx_valid,
    output logic [31:0]        gfx_data,
    input  logic               gfx_ready,
    output logic               unp_valid,
    output logic [31:0]        unp_data,
    output logic [31:0]        unp_cmd,
    input  logic               unp_ready,
    output logic               data_wait,
    output logic               cmd_err
);

    logic              s_valid;
    logic              s_ready;
    logic [WORD_W-1:0] s_data;
    cmd_kind_e         dec_kind;
    logic [REM_W-1:0]  dec_len;

    vifp_tag_strip u_strip (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_tagged (in_tagged),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready)
    );

    vifp_cmd_decode u_dec (
        .cmd     (s_data),
        .kind    (dec_kind),
        .pay_len (dec_len)
    );

    vifp_payload_seq #(.CODE_AW(CODE_AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .dec_kind  (dec_kind),
        .dec_len   (dec_len),
        .code_we   (code_we),
        .code_addr (code_addr),
        .code_data (code_data),
        .gfx_valid (gfx_valid),
        .gfx_data  (gfx_data),
        .gfx_ready (gfx_ready),
        .unp_valid (unp_valid),
        .unp_data  (unp_data),
        .unp_cmd   (unp_cmd),
        .unp_ready (unp_ready),
        .data_wait (data_wait),
        .cyc_we    (cyc_we),
        .cyc_wl    (cyc_wl),
        .cyc_cl    (cyc_cl),
        .cmd_err   (cmd_err)
    );

endmodule

// File: rtl/vifp_parser_chk.sv
// Checker: temporal properties of the parser ports, bound to the top module.
module vifp_parser_chk #(
    parameter int unsigned CODE_AW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_sop,
    input logic               in_tagged,
    input logic               in_ready,
    input logic               code_we,
    input logic [CODE_AW-1:0] code_addr,
    input logic               gfx_valid,
    input logic               gfx_ready,
    input logic               unp_valid,
    input logic               unp_ready,
    input logic               data_wait,
    input logic               cyc_we,
    input logic               cmd_err
);

    AST_NO_IDLE_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wait |-> !(code_we || gfx_valid || unp_valid)); // R1
    AST_CYC_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_we |-> $past(in_valid && in_ready && !data_wait)); // R2
    AST_CODE_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        code_we && $past(code_we) |-> code_addr == CODE_AW'($past(code_addr) + 1'b1)); // R3
    AST_UNP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        unp_valid && !unp_ready |-> !in_ready); // R5
    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_we, gfx_valid, unp_valid})); // R6
    AST_WAIT_ENDS_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_wait) |-> $past(in_valid && in_ready)); // R6
    AST_TAG_NOT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sop && in_tagged |-> !(code_we || gfx_valid || unp_valid)); // R7
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wait |-> in_ready); // R8
    AST_GFX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        gfx_valid && !gfx_ready |-> !in_ready); // R8
    AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(in_valid && in_ready && !data_wait)); // R9

endmodule

bind vifp_parser vifp_parser_chk #(.CODE_AW(CODE_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_tagged (in_tagged),
    .in_ready  (in_ready),
    .code_we   (code_we),
    .code_addr (code_addr),
    .gfx_valid (gfx_valid),
    .gfx_ready (gfx_ready),
    .unp_valid (unp_valid),
    .unp_ready (unp_ready),
    .data_wait (data_wait),
    .cyc_we    (cyc_we),
    .cmd_err   (cmd_err)
);

// File: tb/test_vifp_parser.sv
// Bench: a behavioural reference model is stepped on every clock and compared.
module test_vifp_parser;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_tagged = 1'b0;
    logic [31:0]   in_data = '0;
    logic          in_ready;
    logic          cyc_we;
    logic [7:0]    cyc_wl, cyc_cl;
    logic          code_we;
    logic [AW-1:0] code_addr;
    logic [31:0]   code_data;
    logic          gfx_valid, gfx_ready = 1'b1;
    logic [31:0]   gfx_data;
    logic          unp_valid, unp_ready = 1'b1;
    logic [31:0]   unp_data, unp_cmd;
    logic          data_wait, cmd_err;

    int n_chk = 0;
    int n_err = 0;
    bit stall_en = 1'b0;
    int rcnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vifp_parser #(.CODE_AW(AW)) i_vifp_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_tagged(in_tagged), .in_data(in_data), .in_ready(in_ready),
        .cyc_we(cyc_we), .cyc_wl(cyc_wl), .cyc_cl(cyc_cl),
        .code_we(code_we), .code_addr(code_addr), .code_data(code_data),
        .gfx_valid(gfx_valid), .gfx_data(gfx_data), .gfx_ready(gfx_ready),
        .unp_valid(unp_valid), .unp_data(unp_data), .unp_cmd(unp_cmd),
        .unp_ready(unp_ready), .data_wait(data_wait), .cmd_err(cmd_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd(input int op, input int cnt, input int imm);
        return {1'b0, 7'(op), 8'(cnt), 16'(imm)};
    endfunction

    // Sink ready pattern, updated away from the rising edge.
    always @(negedge clk) begin
        rcnt++;
        gfx_ready = stall_en ? (rcnt % 3 != 0) : 1'b1;
        unp_ready = stall_en ? (rcnt % 4 != 1) : 1'b1;
    end

    // Reference model state.
    int m_mode = 0;        // 0 idle, 1 code, 2 graphics, 3 unpack
    int m_rem = 0;
    int m_addr = 0;
    bit m_skip = 0;
    logic [31:0] m_cmd = '0;
    bit m_cyc_we = 0, m_err = 0;
    int m_wl = 0, m_cl = 0;

    function automatic int unp_len(input int op, input int cnt);
        int n, comps, bpv;
        n = (cnt == 0) ? 256 : cnt;
        comps = ((op >> 2) & 3) + 1;
        case (op & 3)
            0: bpv = comps * 32;
            1: bpv = comps * 16;
            2: bpv = comps * 8;
            default: bpv = 16;
        endcase
        return (n * bpv + 31) / 32;
    endfunction

    // Compare every cycle, then advance the model across the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst_n) begin
                m_mode = 0; m_rem = 0; m_addr = 0; m_skip = 0; m_cmd = '0;
                m_cyc_we = 0; m_err = 0; m_wl = 0; m_cl = 0;
            end else begin
                bit drop, e_rdy, fire;
                int op, cnt, imm, n;
                drop = m_skip || (in_sop && in_tagged);
                if (drop || m_mode == 0 || m_mode == 1) e_rdy = 1;
                else if (m_mode == 2) e_rdy = gfx_ready;
                else e_rdy = unp_ready;
                chk(in_ready == e_rdy, "R8/R7", "in_ready", in_ready, e_rdy);
                chk(data_wait == (m_mode != 0), "R6", "data_wait", data_wait, m_mode != 0);
                chk(cyc_we == m_cyc_we, "R2", "cyc_we", cyc_we, m_cyc_we);
                chk(cyc_wl == 8'(m_wl) && cyc_cl == 8'(m_cl), "R2", "cycle reg",
                    {cyc_wl, cyc_cl}, {8'(m_wl), 8'(m_cl)});
                chk(cmd_err == m_err, "R9", "cmd_err", cmd_err, m_err);
                chk(code_we == (in_valid && !drop && m_mode == 1), "R3", "code_we",
                    code_we, in_valid && !drop && m_mode == 1);
                chk(gfx_valid == (in_valid && !drop && m_mode == 2), "R4", "gfx_valid",
                    gfx_valid, in_valid && !drop && m_mode == 2);
                chk(unp_valid == (in_valid && !drop && m_mode == 3), "R5", "unp_valid",
                    unp_valid, in_valid && !drop && m_mode == 3);
                if (code_we) begin
                    chk(code_addr == AW'(m_addr), "R3", "code_addr", code_addr, m_addr % 4096);
                    chk(code_data == in_data, "R3", "code_data", code_data, in_data);
                end
                if (gfx_valid)
                    chk(gfx_data == in_data, "R4", "gfx_data", gfx_data, in_data);
                if (unp_valid) begin
                    chk(unp_data == in_data, "R5", "unp_data", unp_data, in_data);
                    chk(unp_cmd == m_cmd, "R5", "unp_cmd", unp_cmd, m_cmd);
                end
                fire = in_valid && e_rdy;
                m_cyc_we = 0;
                m_err = 0;
                if (fire) begin
                    if (drop) begin
                        m_skip = !m_skip;
                    end else if (m_mode == 0) begin
                        op = int'(in_data[30:24]);
                        cnt = int'(in_data[23:16]);
                        imm = int'(in_data[15:0]);
                        n = (cnt == 0) ? 256 : cnt;
                        if (in_data[31]) m_err = 1;
                        if (op == 0) begin
                        end else if (op == 1) begin
                            m_cyc_we = 1; m_wl = imm >> 8; m_cl = imm & 255;
                        end else if (op == 'h4A) begin
                            m_mode = 1; m_rem = 2 * n; m_addr = (imm * 2) % 4096;
                        end else if (op == 'h50 || op == 'h51) begin
                            m_mode = 2; m_rem = (imm == 0) ? 65536 * 4 : imm * 4;
                        end else if (op >= 'h60) begin
                            m_mode = 3; m_rem = unp_len(op, cnt); m_cmd = in_data;
                        end else begin
                            m_err = 1;
                        end
                    end else begin
                        m_rem--;
                        m_addr = (m_addr + 1) % 4096;
                        if (m_rem == 0) m_mode = 0;
                    end
                end
            end
        end
    end

    // Present one word and hold it until it is accepted.
    task automatic send(input logic [31:0] w, input bit sop = 0, input bit tag = 0);
        bit r;
        in_valid = 1'b1; in_data = w; in_sop = sop; in_tagged = tag;
        forever begin
            #4;
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
        in_valid = 1'b0; in_sop = 1'b0; in_tagged = 1'b0;
    endtask

    task automatic gap(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #4;
        // R10: idle state after reset
        chk(!data_wait && !cyc_we && !cmd_err && in_ready && cyc_wl == 0 && cyc_cl == 0,
            "R10", "reset state", {data_wait, cyc_we, cmd_err, in_ready}, 4'b0001);
        @(negedge clk);

        // R1, R2: no-op and cycle register loads
        send(cmd(0, 5, 'h1234));
        send(cmd(1, 0, 'h0403));
        send(cmd(0, 0, 0));
        send(cmd(1, 9, 'h0201));
        send(cmd(1, 0, 'h0807));
        #4;
        chk(!data_wait, "R1", "idle after no-op", data_wait, 0);
        @(negedge clk);

        // R3: code upload of two doublewords
        send(cmd('h4A, 2, 3));
        for (int k = 0; k < 4; k++) send(32'hA000_0000 + k);
        gap(2);

        // R7, R6: tagged bursts, upload split across them
        send(32'h7A6_0000, 1, 1);
        send(32'h7A6_0001);
        send(cmd('h4A, 1, 5));
        send(32'hB000_0000);
        gap(3);
        send(32'h7A6_0002, 1, 1);
        send(32'h7A6_0003);
        send(32'hB000_0001);
        #4;
        chk(!data_wait, "R7", "upload done after tag skip", data_wait, 0);
        @(negedge clk);

        // R4, R8: graphics passthrough with stalls and a burst split
        stall_en = 1'b1;
        send(cmd('h50, 0, 2));
        for (int k = 0; k < 3; k++) send(32'hC000_0000 + k);
        gap(4);
        send(32'hC0DE_0000, 1, 1);
        send(32'hC0DE_0001);
        for (int k = 3; k < 8; k++) send(32'hC000_0000 + k);
        send(cmd('h51, 7, 1));
        for (int k = 0; k < 4; k++) send(32'hC100_0000 + k);

        // R5: unpack formats, lengths 8, 2, 3, 2
        send(cmd('h6C, 2, 'h10));
        for (int k = 0; k < 8; k++) send(32'hD000_0000 + k);
        send(cmd('h6F, 3, 'h20));
        for (int k = 0; k < 2; k++) send(32'hD100_0000 + k);
        send(cmd('h65, 3, 'h30));
        send(32'hD200_0000);
        gap(3);
        send(32'hD200_0001);
        send(32'hD200_0002);
        send(cmd('h62, 5, 'h40));
        for (int k = 0; k < 2; k++) send(32'hD300_0000 + k);
        stall_en = 1'b0;

        // R9: unknown opcode has no payload; the next word is a command
        send(cmd('h02, 4, 'h55));
        send(cmd(1, 0, 'h1122));
        send(32'h8000_0000);
        gap(2);

        // R3: count 0 means 256, address wraps at the memory size
        send(cmd('h4A, 0, 'h7FF));
        for (int k = 0; k < 512; k++) send(32'hE000_0000 + k);
        #4;
        chk(!data_wait, "R3", "upload of 512 words ended", data_wait, 0);
        @(negedge clk);
        gap(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule